// File: doc/BRIEF.md
# Video Memory Block Copy Engine

This block moves a run of 16-bit words from one place in video memory to another. Software programs a source pointer, a destination pointer, a word count and two direction bits through a byte-wide register port. Writing the upper byte of the count register starts the copy. The engine then alternates reads and writes on a shared memory request port. Each phase holds its request until the memory acknowledges it.

Each pointer walks up or down on its own, as set by its own control bit, and wraps within the 16-bit word space. The engine copies the programmed values into private counters when a copy starts, so register writes made during a copy leave that copy unchanged. When the last word has been written, a one-cycle completion pulse goes to the status and interrupt logic. A write to the upper byte of the sprite-table base register produces a separate one-cycle pulse at once, with no memory traffic.

Top module: `vram_copy_engine`

## Requirements
- R1: After reset `busy`, `mem_req`, `copy_done` and `table_done` are all low.
- R2: A write with `cfg_hi`=1 and `cfg_sel`=0x12 while idle raises `busy` and `mem_req` on the next cycle. The same register with `cfg_hi`=0 only stores the low count byte and starts nothing.
- R3: A copy moves count+1 words, where count is {upper byte written at start, stored low byte}; a count of 0 moves one word.
- R4: Control register (`cfg_sel`=0x0F, low byte) bit 3 set makes the source pointer (`cfg_sel`=0x10) step down by one after each word read; clear makes it step up.
- R5: Control bit 2 set makes the destination pointer (`cfg_sel`=0x11) step down by one after each word written; clear makes it step up.
- R6: Both pointers wrap modulo 2^16 (0xFFFF+1 gives 0x0000; 0x0000-1 gives 0xFFFF).
- R7: Each word takes a read phase (`mem_we`=0, `mem_addr`=source), then a write phase (`mem_we`=1, `mem_addr`=destination, `mem_wdata`=the word read). Each phase holds `mem_req`, `mem_we` and `mem_addr` steady until `mem_ack`.
- R8: `copy_done` pulses high for one cycle, in the cycle after the last write is acknowledged, and `busy` is low in that cycle. There is exactly one pulse per copy.
- R9: While `busy`, another start write is ignored, and writes to the pointer registers do not change the running copy.
- R10: A write with `cfg_hi`=1 and `cfg_sel`=0x13 pulses `table_done` for one cycle on the next cycle. A write to the low byte of that register does not.
- R11: For every register, `cfg_hi`=0 writes the low byte and `cfg_hi`=1 writes the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register byte write strobe |
| cfg_sel | input | 5 | Register selector |
| cfg_hi | input | 1 | 1 selects the high byte, 0 the low byte |
| cfg_byte | input | 8 | Byte written |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for a write phase, 0 for a read phase |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` in a read phase |
| mem_ack | input | 1 | Acknowledges the current phase |
| busy | output | 1 | Copy in progress |
| copy_done | output | 1 | One-cycle pulse when a copy completes |
| table_done | output | 1 | One-cycle pulse after a sprite-table base high-byte write |

## Verification
The assertions check, on every cycle, the local handshake rules. A stalled phase keeps its address and direction. An acknowledged read is always followed by a write. A start write raises `busy`, and `busy` can only rise after a start write. The completion pulse always marks the fall of `busy`, and the table pulse always follows its register write. The word count, the direction and wrap of each pointer, the data actually moved, and the fact that writes during a copy change nothing all depend on the whole transfer. Only the bench scenarios show these, by comparing the design every cycle against a behavioural model and then reading the target memory.

// File: rtl/vram_copy_engine.sv
module vram_copy_engine #(
  parameter logic [4:0] SEL_CTRL  = 5'h0F,
  parameter logic [4:0] SEL_SRC   = 5'h10,
  parameter logic [4:0] SEL_DST   = 5'h11,
  parameter logic [4:0] SEL_LEN   = 5'h12,
  parameter logic [4:0] SEL_TABLE = 5'h13,
  parameter int SRC_DN_BIT = 3,
  parameter int DST_DN_BIT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [4:0]  cfg_sel,
  input  logic        cfg_hi,
  input  logic [7:0]  cfg_byte,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  input  logic        mem_ack,
  output logic        busy,
  output logic        copy_done,
  output logic        table_done
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} state_t;

  state_t      st;
  logic [15:0] src_reg, dst_reg;
  logic [7:0]  cnt_lo;
  logic        src_dn_reg, dst_dn_reg;
  logic [15:0] src_cur, dst_cur, left, word_q;
  logic        src_dn, dst_dn;

  wire start    = cfg_wr && cfg_hi && cfg_sel == SEL_LEN && st == S_IDLE;
  wire last_wr  = st == S_WR && mem_ack && left == 16'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_reg <= '0; dst_reg <= '0; cnt_lo <= '0;
      src_dn_reg <= 1'b0; dst_dn_reg <= 1'b0;
    end else if (cfg_wr) begin
      if (cfg_sel == SEL_SRC) begin
        if (cfg_hi) src_reg[15:8] <= cfg_byte; else src_reg[7:0] <= cfg_byte;
      end
      if (cfg_sel == SEL_DST) begin
        if (cfg_hi) dst_reg[15:8] <= cfg_byte; else dst_reg[7:0] <= cfg_byte;
      end
      if (cfg_sel == SEL_LEN && !cfg_hi) cnt_lo <= cfg_byte;
      if (cfg_sel == SEL_CTRL && !cfg_hi) begin
        src_dn_reg <= cfg_byte[SRC_DN_BIT];
        dst_dn_reg <= cfg_byte[DST_DN_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      src_cur <= '0; dst_cur <= '0; left <= '0; word_q <= '0;
      src_dn <= 1'b0; dst_dn <= 1'b0;
      copy_done <= 1'b0;
    end else begin
      copy_done <= last_wr;
      case (st)
        S_IDLE: if (start) begin
          src_cur <= src_reg;
          dst_cur <= dst_reg;
          left    <= {cfg_byte, cnt_lo};
          src_dn  <= src_dn_reg;
          dst_dn  <= dst_dn_reg;
          st      <= S_RD;
        end
        S_RD: if (mem_ack) begin
          word_q  <= mem_rdata;
          src_cur <= src_dn ? src_cur - 16'd1 : src_cur + 16'd1;
          st      <= S_WR;
        end
        S_WR: if (mem_ack) begin
          dst_cur <= dst_dn ? dst_cur - 16'd1 : dst_cur + 16'd1;
          if (left == 16'd0) st <= S_IDLE;
          else begin
            left <= left - 16'd1;
            st   <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) table_done <= 1'b0;
    else table_done <= cfg_wr && cfg_hi && cfg_sel == SEL_TABLE;
  end

  assign busy      = st != S_IDLE;
  assign mem_req   = busy;
  assign mem_we    = st == S_WR;
  assign mem_addr  = (st == S_WR) ? dst_cur : src_cur;
  assign mem_wdata = word_q;
endmodule

// File: rtl/vram_copy_engine_chk.sv
module vram_copy_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [4:0]  cfg_sel,
  input logic        cfg_hi,
  input logic [7:0]  cfg_byte,
  input logic        mem_req,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic [15:0] mem_rdata,
  input logic        mem_ack,
  input logic        busy,
  input logic        copy_done,
  input logic        table_done
);
  wire start_wr = cfg_wr && cfg_hi && cfg_sel == 5'h12;

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_wr) |=> (busy && mem_req && !mem_we));

  p_rise_needs_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_wr));

  p_hold_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  p_read_then_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));

  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    copy_done |-> (!busy && $past(busy) && $past(mem_we && mem_ack)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    copy_done |=> !copy_done);

  p_table_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_hi && cfg_sel == 5'h13) |=> table_done);

  p_table_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    table_done |-> $past(cfg_wr && cfg_hi && cfg_sel == 5'h13));
endmodule

bind vram_copy_engine vram_copy_engine_chk i_chk (.*);

// File: tb/test_vram_copy_engine.sv
module test_vram_copy_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_hi = 1'b0;
  logic [4:0] cfg_sel = '0;
  logic [7:0] cfg_byte = '0;
  logic mem_req, mem_we, busy, copy_done, table_done;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic mem_ack = 1'b0;

  always #10 clk = ~clk;

  vram_copy_engine i_vram_copy_engine (.*);

  int errors = 0, checks = 0, cyc = 0, wr_acks = 0, dones = 0;
  logic [15:0] mem [logic [15:0]];
  logic [7:0] lfsr = 8'h5B;

  function automatic logic [15:0] pat(logic [15:0] a);
    return a ^ 16'hA5C3 ^ {a[7:0], a[15:8]};
  endfunction
  function automatic logic [15:0] rd(logic [15:0] a);
    return mem.exists(a) ? mem[a] : pat(a);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_ph = 0;
  logic [15:0] r_src = 0, r_dst = 0, m_src = 0, m_dst = 0, m_data = 0;
  logic [7:0] r_lo = 0;
  bit r_sdn = 0, r_ddn = 0, m_sdn = 0, m_ddn = 0, m_done = 0, m_tdone = 0;
  int m_left = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_done = 0; m_tdone = 0; r_src = 0; r_dst = 0; r_lo = 0;
      r_sdn = 0; r_ddn = 0;
    end else begin
      m_done = 0;
      m_tdone = cfg_wr && cfg_hi && cfg_sel == 5'h13;
      case (m_ph)
        0: if (cfg_wr && cfg_hi && cfg_sel == 5'h12) begin
          m_src = r_src; m_dst = r_dst; m_left = {cfg_byte, r_lo};
          m_sdn = r_sdn; m_ddn = r_ddn; m_ph = 1;
        end
        1: if (mem_ack) begin
          m_data = mem_rdata;
          m_src = m_sdn ? m_src - 16'd1 : m_src + 16'd1;
          m_ph = 2;
        end
        default: if (mem_ack) begin
          m_dst = m_ddn ? m_dst - 16'd1 : m_dst + 16'd1;
          if (m_left == 0) begin m_ph = 0; m_done = 1; end
          else begin m_left--; m_ph = 1; end
        end
      endcase
      if (cfg_wr) begin
        if (cfg_sel == 5'h10) begin if (cfg_hi) r_src[15:8] = cfg_byte; else r_src[7:0] = cfg_byte; end
        if (cfg_sel == 5'h11) begin if (cfg_hi) r_dst[15:8] = cfg_byte; else r_dst[7:0] = cfg_byte; end
        if (cfg_sel == 5'h12 && !cfg_hi) r_lo = cfg_byte;
        if (cfg_sel == 5'h0F && !cfg_hi) begin r_sdn = cfg_byte[3]; r_ddn = cfg_byte[2]; end
      end
    end
  end

  // per-cycle compare, then memory response for this cycle
  always @(negedge clk) begin
    if (rst_n) begin
      check(busy == (m_ph != 0), "R2 busy", busy, m_ph != 0);
      check(mem_req == (m_ph != 0), "R7 mem_req", mem_req, m_ph != 0);
      check(copy_done == m_done, "R8 copy_done", copy_done, m_done);
      check(table_done == m_tdone, "R10 table_done", table_done, m_tdone);
      if (m_ph != 0) begin
        check(mem_we == (m_ph == 2), "R7 mem_we", mem_we, m_ph == 2);
        check(mem_addr == (m_ph == 2 ? m_dst : m_src), "R4 R5 R6 mem_addr",
              mem_addr, m_ph == 2 ? m_dst : m_src);
        if (m_ph == 2) check(mem_wdata == m_data, "R7 mem_wdata", mem_wdata, m_data);
      end
      if (copy_done) dones++;
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ack = mem_req && (lfsr[0] || lfsr[2]);
    mem_rdata = mem_req ? rd(mem_addr) : 16'h0;
    if (mem_req && mem_we && mem_ack) begin
      mem[mem_addr] = mem_wdata;
      wr_acks++;
    end
  end

  task automatic wreg(logic [4:0] sel, logic hi, logic [7:0] b);
    cfg_sel = sel; cfg_hi = hi; cfg_byte = b; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic prog(logic [15:0] s, logic [15:0] d, logic [15:0] n, logic [7:0] c);
    wreg(5'h0F, 0, c);
    wreg(5'h10, 0, s[7:0]); wreg(5'h10, 1, s[15:8]);
    wreg(5'h11, 0, d[7:0]); wreg(5'h11, 1, d[15:8]);
    wreg(5'h12, 0, n[7:0]); wreg(5'h12, 1, n[15:8]);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) if (cyc == 150000) begin
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !mem_req && !copy_done && !table_done, "R1 reset outputs",
          {busy, mem_req, copy_done, table_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: low count byte alone starts nothing
    wreg(5'h12, 0, 8'h03);
    repeat (3) @(negedge clk);
    check(!busy, "R2 low byte no start", busy, 0);

    // R3 R11: up/up copy of 4 words
    wr_acks = 0; dones = 0;
    prog(16'h0100, 16'h2000, 16'h0003, 8'h00);
    wait_idle();
    check(wr_acks == 4, "R3 words moved", wr_acks, 4);
    check(dones == 1, "R8 one done pulse", dones, 1);
    for (int i = 0; i < 4; i++)
      check(rd(16'h2000 + 16'(i)) == pat(16'h0100 + 16'(i)), "R3 data",
            rd(16'h2000 + 16'(i)), pat(16'h0100 + 16'(i)));
    check(rd(16'h2004) == pat(16'h2004), "R3 no extra word", rd(16'h2004), pat(16'h2004));

    // R3: count 0 moves one word, both down
    wr_acks = 0;
    prog(16'h0500, 16'h5000, 16'h0000, 8'h0C);
    wait_idle();
    check(wr_acks == 1, "R3 count zero", wr_acks, 1);
    check(rd(16'h5000) == pat(16'h0500), "R5 single word", rd(16'h5000), pat(16'h0500));
    check(rd(16'h4FFF) == pat(16'h4FFF), "R3 single only", rd(16'h4FFF), pat(16'h4FFF));

    // R4 R6: source down through zero, destination up
    prog(16'h0001, 16'h3000, 16'h0003, 8'h08);
    wait_idle();
    for (int i = 0; i < 4; i++)
      check(rd(16'h3000 + 16'(i)) == pat(16'h0001 - 16'(i)), "R4 R6 src down wrap",
            rd(16'h3000 + 16'(i)), pat(16'h0001 - 16'(i)));

    // R5 R6: source up through 0xFFFF, destination down
    prog(16'hFFFE, 16'h4003, 16'h0003, 8'h04);
    wait_idle();
    for (int i = 0; i < 4; i++)
      check(rd(16'h4003 - 16'(i)) == pat(16'hFFFE + 16'(i)), "R5 R6 dst down",
            rd(16'h4003 - 16'(i)), pat(16'hFFFE + 16'(i)));

    // R9: restart and pointer writes during a copy are ignored
    wr_acks = 0; dones = 0;
    prog(16'h0700, 16'h6000, 16'h0005, 8'h00);
    @(negedge clk);
    wreg(5'h10, 0, 8'h55);
    wreg(5'h12, 1, 8'hFF);
    wait_idle();
    check(wr_acks == 6, "R9 restart ignored", wr_acks, 6);
    check(dones == 1, "R9 R8 single done", dones, 1);
    check(rd(16'h6005) == pat(16'h0705), "R9 source unchanged", rd(16'h6005), pat(16'h0705));

    // R10: table base high byte pulses, low byte does not
    wreg(5'h13, 0, 8'h12);
    @(negedge clk);
    check(!table_done, "R10 low byte silent", table_done, 0);
    wreg(5'h13, 1, 8'h34);
    check(table_done, "R10 pulse", table_done, 1);
    @(negedge clk);
    check(!table_done, "R10 one cycle", table_done, 0);

    summary();
  end
endmodule